// File: doc/BRIEF.md
# Phase Skew Auto-Calibration Controller

This controller places a sampling clock phase in the middle of the range where a clock-domain-crossing synchronizer runs without timing errors. It works through a clock manager's fine phase-shift port, one step at a time, and watches a sticky error flag from an external pattern checker. A test of one phase position pulses the flag's clear input, waits a settling interval and then reads the flag: a set flag means a failure was seen at that position.

Calibration runs two edge searches in the forward direction. The first finds the position where errors stop and reports its step count as the lead. The second finds where errors start again and reports the count as the width of the error-free range. The controller then takes width/2 reverse steps (rounded down) and signals done. If either search runs past its step budget without finding its edge, the controller stops and signals failure. A single start pulse launches a run; the control and status pins are plain levels and pulses, with no handshake at the block's edge apart from the clock manager's step-done signal.

Top module: `phase_cal_ctrl`

## Requirements
- R1: After reset `done_o`, `fail_o`, `ps_req_o` and `err_clr_o` are low and `lead_o`, `width_o` and `width_deg_o` are zero.
- R2: Each measurement is a one-cycle `err_clr_o` pulse, then a wait of SETTLE_CYC = CLK_HZ*SETTLE_US/1e6 cycles (minimum 1), then one sample of `err_flag_i` (1 = error seen). No phase step is requested during a measurement. A run makes exactly (lead+1)+(width+1) measurements.
- R3: A step request is a one-cycle `ps_req_o` pulse, issued only when `ps_done_i` was high. After the request the controller waits for `ps_done_i` to be high again before any further step or measurement.
- R4: The first search takes one measurement before stepping and stores it as the previous result. Each iteration makes one forward step, increments the count and measures again. The search ends when the previous result was 1 and the current one is 0, and that count is reported on `lead_o`.
- R5: The second search starts from a zero count with a fresh first measurement. It ends when the previous result was 0 and the current one is 1, and that count is reported on `width_o`.
- R6: After both searches succeed the controller issues floor(width/2) reverse steps, then raises `done_o`. `ps_dir_o` is 1 for forward and 0 for reverse, and reverse steps occur only in this phase.
- R7: If a search's count exceeds MAX_STEPS without an edge, the controller stops after exactly MAX_STEPS+1 steps of that search and raises `fail_o`.
- R8: `done_o` and `fail_o` are never high together. Whichever is high stays high until the next `start_i`, which clears both in the following cycle.
- R9: A `start_i` pulse that arrives while a run is in progress has no effect on the run's results or its step and measurement counts.
- R10: `width_deg_o` equals floor(width*360/STEPS_PER_TURN); the default STEPS_PER_TURN is 448.
- R11: A width of 1 gives zero reverse steps, so `done_o` follows directly after the width search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that starts a calibration |
| ps_done_i | input | 1 | Clock manager step status, high when idle (1 out of reset) |
| err_flag_i | input | 1 | Sticky synchronizer error flag |
| ps_req_o | output | 1 | One-cycle phase step request |
| ps_dir_o | output | 1 | Step direction: 1 forward, 0 reverse |
| err_clr_o | output | 1 | One-cycle clear pulse for the error flag |
| lead_o | output | CNT_W | Steps to the end of the error region |
| width_o | output | CNT_W | Steps across the error-free region |
| width_deg_o | output | CNT_W | Width in degrees |
| done_o | output | 1 | Calibration finished, phase centred |
| fail_o | output | 1 | Edge not found within the step budget |

## Verification
The bench sets CLK_HZ to 1 MHz and SETTLE_US to 8, so each measurement settles in 8 cycles instead of hundreds of thousands. It also sets MAX_STEPS to 40, so that both failure outcomes (errors at every position, and no error at any position) are reached after 41 steps. The phase model is a periodic 30-step pass window, which brings runs that start inside the window, odd widths and a width of one within a few thousand cycles.

// File: rtl/phase_cal_pkg.sv
package phase_cal_pkg;

  typedef enum logic [2:0] {
    CAL_IDLE,
    CAL_CLR,
    CAL_SETTLE,
    CAL_STEP,
    CAL_DONE,
    CAL_FAIL
  } cal_state_e;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_ISSUE,
    HS_GAP,
    HS_WAIT
  } hs_state_e;

  localparam int DEG_FULL = 360;

endpackage

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
  parameter int CYC = 8,
  parameter int W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expire_o
);

  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= W'(CYC - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == '0) && !load_i;

  // R2
  expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

endmodule

// File: rtl/cal_ps_handshake.sv
module cal_ps_handshake
  import phase_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic dir_i,
  input  logic ps_done_i,
  output logic ps_req_o,
  output logic ps_dir_o,
  output logic ack_o
);

  hs_state_e st_q;
  logic      dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= HS_IDLE;
      dir_q <= 1'b1;
    end else begin
      unique case (st_q)
        HS_IDLE: if (go_i && ps_done_i) begin
          st_q  <= HS_ISSUE;
          dir_q <= dir_i;
        end
        HS_ISSUE: st_q <= HS_GAP;
        HS_GAP:   st_q <= HS_WAIT;
        HS_WAIT:  if (ps_done_i) st_q <= HS_IDLE;
        default:  st_q <= HS_IDLE;
      endcase
    end
  end

  assign ps_req_o = (st_q == HS_ISSUE);
  assign ps_dir_o = dir_q;
  assign ack_o    = (st_q == HS_WAIT) && ps_done_i;

  // R3
  req_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ps_req_o |-> $past(ps_done_i));
  // R3
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ps_req_o |=> !ps_req_o);

endmodule

// File: rtl/phase_cal_ctrl.sv
module phase_cal_ctrl
  import phase_cal_pkg::*;
#(
  parameter int CLK_HZ         = 100_000_000,
  parameter int SETTLE_US      = 5000,
  parameter int MAX_STEPS      = 5000,
  parameter int STEPS_PER_TURN = 448,
  parameter int CNT_W          = $clog2(MAX_STEPS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ps_done_i,
  input  logic             err_flag_i,
  output logic             ps_req_o,
  output logic             ps_dir_o,
  output logic             err_clr_o,
  output logic [CNT_W-1:0] lead_o,
  output logic [CNT_W-1:0] width_o,
  output logic [CNT_W-1:0] width_deg_o,
  output logic             done_o,
  output logic             fail_o
);

  localparam longint SETTLE_RAW = (longint'(CLK_HZ) * longint'(SETTLE_US)) / 64'd1000000;
  localparam int     SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : int'(SETTLE_RAW);
  localparam int     SET_W      = $clog2(SETTLE_CYC + 1);
  localparam int     PROD_W     = CNT_W + 9;

  cal_state_e       st_q;
  logic             search_q;   // 0: lead search, 1: width search
  logic             first_q;
  logic             prev_q;
  logic             back_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] back_cnt_q;
  logic [CNT_W-1:0] lead_q;
  logic [CNT_W-1:0] width_q;

  logic step_go, step_ack, settle_exp, busy, cur, edge_hit;
  logic [PROD_W-1:0] deg_prod;

  assign busy      = (st_q == CAL_CLR) || (st_q == CAL_SETTLE) || (st_q == CAL_STEP);
  assign step_go   = (st_q == CAL_STEP);
  assign err_clr_o = (st_q == CAL_CLR);
  assign cur       = err_flag_i;
  assign edge_hit  = (prev_q != search_q) && (cur == search_q);

  cal_settle_timer #(.CYC(SETTLE_CYC), .W(SET_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (err_clr_o),
    .expire_o (settle_exp)
  );

  cal_ps_handshake u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (step_go),
    .dir_i     (!back_q),
    .ps_done_i (ps_done_i),
    .ps_req_o  (ps_req_o),
    .ps_dir_o  (ps_dir_o),
    .ack_o     (step_ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= CAL_IDLE;
      search_q   <= 1'b0;
      first_q    <= 1'b1;
      prev_q     <= 1'b0;
      back_q     <= 1'b0;
      cnt_q      <= '0;
      back_cnt_q <= '0;
      lead_q     <= '0;
      width_q    <= '0;
    end else begin
      unique case (st_q)
        CAL_IDLE, CAL_DONE, CAL_FAIL: begin
          if (start_i) begin
            st_q     <= CAL_CLR;
            search_q <= 1'b0;
            first_q  <= 1'b1;
            back_q   <= 1'b0;
            cnt_q    <= '0;
            lead_q   <= '0;
            width_q  <= '0;
          end
        end
        CAL_CLR: st_q <= CAL_SETTLE;
        CAL_SETTLE: begin
          if (settle_exp) begin
            if (first_q) begin
              prev_q  <= cur;
              first_q <= 1'b0;
              st_q    <= CAL_STEP;
            end else if (edge_hit) begin
              if (!search_q) begin
                lead_q   <= cnt_q;
                search_q <= 1'b1;
                cnt_q    <= '0;
                first_q  <= 1'b1;
                st_q     <= CAL_CLR;
              end else begin
                width_q    <= cnt_q;
                back_cnt_q <= cnt_q >> 1;
                back_q     <= 1'b1;
                st_q       <= ((cnt_q >> 1) == '0) ? CAL_DONE : CAL_STEP;
              end
            end else if (cnt_q > CNT_W'(MAX_STEPS)) begin
              st_q <= CAL_FAIL;
            end else begin
              prev_q <= cur;
              st_q   <= CAL_STEP;
            end
          end
        end
        CAL_STEP: begin
          if (step_ack) begin
            if (back_q) begin
              back_cnt_q <= back_cnt_q - 1'b1;
              if (back_cnt_q == CNT_W'(1)) st_q <= CAL_DONE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              st_q  <= CAL_CLR;
            end
          end
        end
        default: st_q <= CAL_IDLE;
      endcase
    end
  end

  assign deg_prod    = PROD_W'(width_q) * PROD_W'(DEG_FULL);
  assign width_deg_o = CNT_W'(deg_prod / PROD_W'(STEPS_PER_TURN));
  assign lead_o      = lead_q;
  assign width_o     = width_q;
  assign done_o      = (st_q == CAL_DONE);
  assign fail_o      = (st_q == CAL_FAIL);

  // R8
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> fail_o);
  // R2
  no_step_in_measure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_clr_o && ps_req_o));
  // R7
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_STEPS + 1));
  // R6
  reverse_after_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_req_o && !ps_dir_o) |-> (width_o != '0));
  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && st_q == CAL_STEP) |=> !err_clr_o || $past(step_ack));

endmodule

// File: tb/phase_cal_ctrl_tb_top.sv
module phase_cal_ctrl_tb_top;

  localparam int MAXS = 40;
  localparam int CW   = $clog2(MAXS + 2);
  localparam int PER  = 30;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ps_done = 1'b1, err_flag = 1'b0;
  logic ps_req, ps_dir, err_clr, done, fail;
  logic [CW-1:0] lead, width, deg;

  int nchk = 0, nfail = 0, cyc = 0;
  int pos = 0, busy_cnt = 0, nreq = 0, nrev = 0, nclr = 0;
  int glo = 5, ghi = 16;
  bit dir_l = 1'b1;

  always #2.5 clk = ~clk;

  phase_cal_ctrl #(.CLK_HZ(1_000_000), .SETTLE_US(8), .MAX_STEPS(MAXS),
                   .STEPS_PER_TURN(448), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ps_done_i(ps_done),
    .err_flag_i(err_flag), .ps_req_o(ps_req), .ps_dir_o(ps_dir),
    .err_clr_o(err_clr), .lead_o(lead), .width_o(width),
    .width_deg_o(deg), .done_o(done), .fail_o(fail));

  function automatic bit bad(input int p);
    int m;
    m = p % PER;
    if (m < 0) m += PER;
    return !(m >= glo && m <= ghi);
  endfunction

  // clock manager and sticky error flag model
  always @(negedge clk) begin
    if (!rst_n) begin
      ps_done  <= 1'b1;
      err_flag <= 1'b0;
      busy_cnt = 0;
    end else begin
      if (ps_req) begin
        ps_done <= 1'b0;
        busy_cnt = 3;
        dir_l = ps_dir;
        nreq++;
        if (!ps_dir) nrev++;
      end else if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0) begin
          pos += dir_l ? 1 : -1;
          ps_done <= 1'b1;
        end
      end
      if (err_clr) begin
        err_flag <= 1'b0;
        nclr++;
      end else if (bad(pos)) begin
        err_flag <= 1'b1;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL R7 watchdog: actual %0d cycles, expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference search over the phase model
  task automatic ref_search(inout int p, input bit tgt, output int cnt, output bit ok);
    bit prev, cur;
    prev = bad(p); cnt = 0; ok = 0;
    forever begin
      p++; cnt++;
      cur = bad(p);
      if (prev != tgt && cur == tgt) begin ok = 1; return; end
      if (cnt > MAXS) return;
      prev = cur;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      if (done || fail) return;
      @(negedge clk);
    end
  endtask

  task automatic run_compare(input int lo, input int hi, input bit extra_start);
    int p, l, w, c1, c2, steps, clrs, rev;
    bit ok1, ok2, ok;
    glo = lo; ghi = hi;
    p = pos;
    ref_search(p, 1'b0, l, ok1);
    w = 0; ok2 = 0;
    if (ok1) ref_search(p, 1'b1, w, ok2);
    ok = ok1 && ok2;
    rev = ok ? w / 2 : 0;
    p = p - rev;
    c1 = l; c2 = w;
    steps = ok ? (l + w + rev) : (ok1 ? l + MAXS + 1 : MAXS + 1);
    clrs  = ok ? (l + 1 + w + 1) : (ok1 ? (l + 1 + MAXS + 2) : MAXS + 2);
    @(negedge clk);
    nreq = 0; nrev = 0; nclr = 0;
    pulse_start();
    if (extra_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_end();
    check(done == ok, "R8 done", done, ok);
    check(fail == !ok, "R7 fail", fail, !ok);
    check(nreq == steps, extra_start ? "R9 step count" : "R3 step count", nreq, steps);
    check(nclr == clrs, "R2 measurement count", nclr, clrs);
    if (ok) begin
      check(lead == c1, "R4 lead", lead, c1);
      check(width == c2, "R5 width", width, c2);
      check(nrev == rev, "R6 reverse steps", nrev, rev);
      check(pos == p, "R6 final phase", pos, p);
      check(deg == (c2 * 360) / 448, "R10 degrees", deg, (c2 * 360) / 448);
    end
  endtask

  task automatic t_reset();
    check(!done && !fail, "R1 flags", {done, fail}, 0);
    check(!ps_req && !err_clr, "R1 pulses", {ps_req, err_clr}, 0);
    check(lead == 0 && width == 0 && deg == 0, "R1 counts", lead + width, 0);
  endtask

  task automatic t_width_one();
    run_compare(4, 4, 1'b0);
    check(width == 1 && nrev == 0, "R11 no reverse for width 1", nrev, 0);
  endtask

  task automatic t_hold_and_restart();
    run_compare(7, 20, 1'b0);
    repeat (25) @(negedge clk);
    check(done == 1'b1, "R8 done held", done, 1);
    pulse_start();
    check(!done && !fail, "R8 cleared by start", done, 0);
    wait_end();
    check(done == 1'b1, "R8 rerun done", done, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_compare(5, 16, 1'b0);   // R4 R5 start in error region
    run_compare(5, 16, 1'b0);   // R4 start inside pass window
    run_compare(3, 9, 1'b0);    // R6 odd width
    t_width_one();
    run_compare(10, 2, 1'b0);   // R7 error everywhere
    run_compare(0, PER - 1, 1'b0); // R7 never an error
    run_compare(12, 25, 1'b1);  // R9 extra start mid-run
    t_hold_and_restart();
    summary();
    $finish;
  end

endmodule